// File: doc/BRIEF.md
# Multi-Mode Display Timing Generator

This block produces the raster timing for a parallel RGB panel, one pixel per clock. It runs a horizontal and a vertical position counter and decodes them into a data-enable strobe, an active-high horizontal sync and an active-high vertical sync. It also outputs the x/y coordinate of the pixel currently being driven. A 3-bit mode code picks one of five built-in timings at run time. The pixel path downstream uses the enable and the coordinates to fetch and drive pixel data. All outputs change just after the rising clock edge.

Each line is laid out as active pixels, then front porch, then sync, then back porch. Each frame is laid out the same way, in lines. A change of the mode code is only taken up when the last pixel of a frame has been sent. Two code values have no timing. While one of them is selected, the generator raises an error flag and keeps all strobes low. When a legal code appears again, it restarts on the very next clock.

Top module: `disp_timing_gen`

## Requirements
- R1: While rst_n is low, de, hsync, vsync and code_err are 0 and px_x and px_y are 0.
- R2: de is 1 for the first `active` clocks of every line that lies inside the active lines. px_x counts up by one per clock from 0 while de is 1. px_x and px_y read 0 whenever de is 0.
- R3: The horizontal timing per code is given as active/front/sync/back. Code 7 is 800/40/1/216. Code 6 is 640/24/1/136. Codes 5 and 4 are both 480/2/1/43. Code 0 is 400/20/1/108. hsync is 1 for exactly one clock, at line position active+front, and a line lasts active+front+sync+back clocks.
- R4: The vertical timing per code is given as active/front/sync/back lines. Code 7 is 480/10/1/35. Code 6 is 480/18/1/27. Code 5 is 272/2/1/12. Code 4 is 640/4/1/8. Code 0 is 240/2/1/20. vsync is 1 for the whole line at vertical position active+front. de is 0 outside the active lines, and px_y gives the line index while de is 1.
- R5: Code 1 produces exactly the timing of code 5.
- R6: Codes 2 and 3 set code_err to 1 from the clock that takes them up. They hold de, hsync and vsync at 0. When a legal code is then presented, the next clock clears code_err and starts a frame at pixel (0,0).
- R7: A code change while a legal frame is running has no effect until the last pixel of that frame. The new timing applies from the first pixel of the next frame.
- R8: The first rising edge after rst_n goes high takes up mode_code. If the code is legal, de is 1 with px_x = 0 and px_y = 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_code | input | 3 | Requested timing code |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| de | output | 1 | Active-video data enable |
| px_x | output | 11 | Current pixel column, 0 outside active video |
| px_y | output | 11 | Current pixel row, 0 outside active video |
| code_err | output | 1 | Selected code has no timing |

## Verification
On every cycle the assertions check several properties that hold in every mode. The strobes stay quiet while code_err is set. hsync lasts one clock. Neither sync overlaps de. The coordinates read zero outside active video, and px_x advances by one across active pixels. Only the bench scenarios can show that each code yields its own porch positions and line length. The same holds for the alias of code 1 onto code 5, the recovery from an illegal code, and the fact that a mid-frame code change is held off until the frame wraps. That last point is shown across one complete frame.

// File: rtl/disp_timing_gen.sv
module disp_timing_gen #(
  parameter int CNT_W  = 11,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] mode_code,
  output logic              hsync,
  output logic              vsync,
  output logic              de,
  output logic [CNT_W-1:0]  px_x,
  output logic [CNT_W-1:0]  px_y,
  output logic              code_err
);

  typedef struct packed {
    logic [CNT_W-1:0] act;
    logic [CNT_W-1:0] fp;
    logic [CNT_W-1:0] sw;
    logic [CNT_W-1:0] bp;
  } span_t;

  function automatic span_t mk(input int a, input int f, input int s, input int b);
    span_t r;
    r.act = CNT_W'(a);
    r.fp  = CNT_W'(f);
    r.sw  = CNT_W'(s);
    r.bp  = CNT_W'(b);
    return r;
  endfunction

  function automatic span_t h_span(input logic [CODE_W-1:0] c);
    case (c)
      CODE_W'(6):             return mk(640, 24, 1, 136);
      CODE_W'(5), CODE_W'(1): return mk(480, 2, 1, 43);
      CODE_W'(4):             return mk(480, 2, 1, 43);
      CODE_W'(0):             return mk(400, 20, 1, 108);
      default:                return mk(800, 40, 1, 216);
    endcase
  endfunction

  function automatic span_t v_span(input logic [CODE_W-1:0] c);
    case (c)
      CODE_W'(6):             return mk(480, 18, 1, 27);
      CODE_W'(5), CODE_W'(1): return mk(272, 2, 1, 12);
      CODE_W'(4):             return mk(640, 4, 1, 8);
      CODE_W'(0):             return mk(240, 2, 1, 20);
      default:                return mk(480, 10, 1, 35);
    endcase
  endfunction

  function automatic logic code_ok(input logic [CODE_W-1:0] c);
    case (c)
      CODE_W'(0), CODE_W'(1), CODE_W'(4),
      CODE_W'(5), CODE_W'(6), CODE_W'(7): return 1'b1;
      default:                            return 1'b0;
    endcase
  endfunction

  logic [CODE_W-1:0] cur_code;
  logic [CNT_W-1:0]  h_cnt, v_cnt;
  logic              live, err_q;

  span_t hs_t, vs_t;
  logic [CNT_W-1:0] h_end, v_end, h_sync_at, v_sync_at;
  logic line_end, frame_end, reload;
  logic h_act, v_act, h_in_sync, v_in_sync;

  assign hs_t      = h_span(cur_code);
  assign vs_t      = v_span(cur_code);
  assign h_end     = hs_t.act + hs_t.fp + hs_t.sw + hs_t.bp - CNT_W'(1);
  assign v_end     = vs_t.act + vs_t.fp + vs_t.sw + vs_t.bp - CNT_W'(1);
  assign h_sync_at = hs_t.act + hs_t.fp;
  assign v_sync_at = vs_t.act + vs_t.fp;
  assign line_end  = (h_cnt == h_end);
  assign frame_end = line_end && (v_cnt == v_end);
  assign reload    = !live || frame_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_code <= '0;
      live     <= 1'b0;
      err_q    <= 1'b0;
      h_cnt    <= '0;
      v_cnt    <= '0;
    end else if (reload) begin
      cur_code <= mode_code;
      live     <= code_ok(mode_code);
      err_q    <= !code_ok(mode_code);
      h_cnt    <= '0;
      v_cnt    <= '0;
    end else if (line_end) begin
      h_cnt <= '0;
      v_cnt <= v_cnt + CNT_W'(1);
    end else begin
      h_cnt <= h_cnt + CNT_W'(1);
    end
  end

  assign h_act     = (h_cnt < hs_t.act);
  assign v_act     = (v_cnt < vs_t.act);
  assign h_in_sync = (h_cnt >= h_sync_at) && (h_cnt < h_sync_at + hs_t.sw);
  assign v_in_sync = (v_cnt >= v_sync_at) && (v_cnt < v_sync_at + vs_t.sw);

  assign de       = live && h_act && v_act;
  assign hsync    = live && h_in_sync;
  assign vsync    = live && v_in_sync;
  assign px_x     = de ? h_cnt : '0;
  assign px_y     = de ? v_cnt : '0;
  assign code_err = err_q;

endmodule

// File: rtl/disp_timing_gen_chk.sv
module disp_timing_gen_chk #(
  parameter int CNT_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hsync,
  input logic             vsync,
  input logic             de,
  input logic [CNT_W-1:0] px_x,
  input logic [CNT_W-1:0] px_y,
  input logic             code_err
);

  AST_QUIET_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    code_err |-> (!de && !hsync && !vsync)); // R6

  AST_HSYNC_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    hsync |=> !hsync); // R3

  AST_HSYNC_NOT_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    hsync |-> !de); // R3

  AST_VSYNC_NOT_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    vsync |-> !de); // R4

  AST_COORD_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !de |-> (px_x == '0 && px_y == '0)); // R2

  AST_X_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (de && $past(de)) |-> (px_x == $past(px_x) + CNT_W'(1) && px_y == $past(px_y))); // R2

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!de && !hsync && !vsync && !code_err) || rst_n); // R1

endmodule

bind disp_timing_gen disp_timing_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync), .de(de),
  .px_x(px_x), .px_y(px_y), .code_err(code_err)
);

// File: tb/disp_timing_gen_bench.sv
module disp_timing_gen_bench;
  localparam int CNT_W = 11;
  localparam int HT0   = 529;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] mode_code = 3'd0;
  logic hsync, vsync, de, code_err;
  logic [CNT_W-1:0] px_x, px_y;
  int checks = 0;
  int fails = 0;
  int pos = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  disp_timing_gen #(.CNT_W(CNT_W), .CODE_W(3)) u_disp_timing_gen (
    .clk(clk), .rst_n(rst_n), .mode_code(mode_code), .hsync(hsync),
    .vsync(vsync), .de(de), .px_x(px_x), .px_y(px_y), .code_err(code_err)
  );

  typedef struct packed {
    logic [2:0]       code;
    logic [31:0]      steps;
    logic             e_de;
    logic             e_hs;
    logic [CNT_W-1:0] e_x;
    logic [CNT_W-1:0] e_y;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{3'd7,   0, 1'b1, 1'b0, 11'd0,   11'd0},
    '{3'd7, 799, 1'b1, 1'b0, 11'd799, 11'd0},
    '{3'd7, 800, 1'b0, 1'b0, 11'd0,   11'd0},
    '{3'd7, 840, 1'b0, 1'b1, 11'd0,   11'd0},
    '{3'd7, 841, 1'b0, 1'b0, 11'd0,   11'd0},
    '{3'd7, 1057, 1'b1, 1'b0, 11'd0,  11'd1},
    '{3'd6, 639, 1'b1, 1'b0, 11'd639, 11'd0},
    '{3'd6, 664, 1'b0, 1'b1, 11'd0,   11'd0},
    '{3'd6, 665, 1'b0, 1'b0, 11'd0,   11'd0},
    '{3'd6, 801, 1'b1, 1'b0, 11'd0,   11'd1},
    '{3'd5, 481, 1'b0, 1'b0, 11'd0,   11'd0},
    '{3'd5, 482, 1'b0, 1'b1, 11'd0,   11'd0},
    '{3'd1, 479, 1'b1, 1'b0, 11'd479, 11'd0},
    '{3'd1, 482, 1'b0, 1'b1, 11'd0,   11'd0},
    '{3'd1, 526, 1'b1, 1'b0, 11'd0,   11'd1},
    '{3'd4, 482, 1'b0, 1'b1, 11'd0,   11'd0},
    '{3'd0, 399, 1'b1, 1'b0, 11'd399, 11'd0},
    '{3'd0, 420, 1'b0, 1'b1, 11'd0,   11'd0},
    '{3'd0, 529, 1'b1, 1'b0, 11'd0,   11'd1}
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic restart(input logic [2:0] c);
    @(negedge clk);
    rst_n = 1'b0;
    mode_code = c;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic goto_pos(input int target);
    repeat (target - pos) @(posedge clk);
    @(negedge clk);
    pos = target;
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      report();
    end
  end

  initial begin
    mode_code = 3'd6;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "reset quiet", {de, hsync, vsync, code_err}, 4'b0000);
    chk("R1", "reset coords", {px_x, px_y}, '0);

    for (int i = 0; i < NV; i++) begin
      string rq;
      rq = (VECS[i].code == 3'd1) ? "R5" : ((VECS[i].e_y != 0) ? "R3 line length" : "R2/R3");
      restart(VECS[i].code);
      repeat (VECS[i].steps + 1) @(posedge clk);
      @(negedge clk);
      chk(rq, "de", de, VECS[i].e_de);
      chk(rq, "hsync", hsync, VECS[i].e_hs);
      chk(rq, "px_x", px_x, VECS[i].e_x);
      chk(rq, "px_y", px_y, VECS[i].e_y);
    end

    // R8: first edge after reset release starts at pixel (0,0)
    restart(3'd4);
    @(posedge clk);
    @(negedge clk);
    chk("R8", "de/err", {de, code_err}, 2'b10);
    chk("R8", "coords", {px_x, px_y}, '0);

    // R6: illegal codes
    restart(3'd2);
    @(posedge clk);
    @(negedge clk);
    chk("R6", "err on code 2", code_err, 1'b1);
    begin
      int busy = 0;
      for (int k = 0; k < 600; k++) begin
        if (de || hsync || vsync) busy++;
        @(negedge clk);
      end
      chk("R6", "strobes while illegal", busy, 0);
    end
    mode_code = 3'd3;
    @(posedge clk);
    @(negedge clk);
    chk("R6", "err on code 3", {code_err, de, hsync, vsync}, 4'b1000);
    mode_code = 3'd6;
    @(posedge clk);
    @(negedge clk);
    chk("R6", "recovery err/de", {code_err, de}, 2'b01);
    chk("R6", "recovery coords", {px_x, px_y}, '0);
    @(posedge clk);
    @(negedge clk);
    chk("R6", "recovery step", px_x, 1);

    // R7 and R4: full frame of code 0, code changed to 7 mid-frame
    restart(3'd0);
    @(posedge clk);
    @(negedge clk);
    pos = 0;
    mode_code = 3'd7;
    goto_pos(400);
    chk("R7", "old width kept", de, 1'b0);
    goto_pos(239 * HT0 + 5);
    chk("R4", "last active line", {de, px_x, px_y}, {1'b1, 11'd5, 11'd239});
    goto_pos(240 * HT0);
    chk("R4", "first blank line", {de, vsync}, 2'b00);
    goto_pos(241 * HT0 + 3);
    chk("R4", "before vsync", vsync, 1'b0);
    goto_pos(242 * HT0);
    chk("R4", "vsync line start", {vsync, de}, 2'b10);
    goto_pos(242 * HT0 + 420);
    chk("R4", "vsync with hsync", {vsync, hsync}, 2'b11);
    goto_pos(243 * HT0);
    chk("R4", "vsync ends", vsync, 1'b0);
    goto_pos(263 * HT0 - 1);
    chk("R7", "frame tail", {de, code_err}, 2'b00);
    goto_pos(263 * HT0);
    chk("R7", "new frame start", {de, px_x, px_y}, {1'b1, 11'd0, 11'd0});
    goto_pos(263 * HT0 + 400);
    chk("R7", "new width used", {de, px_x}, {1'b1, 11'd400});
    goto_pos(263 * HT0 + 800);
    chk("R7", "new active end", de, 1'b0);

    done = 1'b1;
    report();
  end
endmodule